// File: doc/BRIEF.md
# External Status Interrupt Latch Unit

This unit gathers six status sources of a serial controller channel into one status word and raises a single combined interrupt. The sources are break/abort, transmit underrun/end-of-message, CTS, DCD, sync/hunt and zero count. Each source has its own latch enable. A master enable gates the combined interrupt output. A latch-enabled source that changes state sets the pending flag and freezes every latch-enabled bit of the status word. The word stays frozen until software issues the reset-status command. Sources whose latch is off always show their live value.

A small state machine controls the latches. It has three states. ST_OPEN means the latches are transparent and nothing is pending. ST_HELD means the latches are closed and an interrupt is pending. ST_HELD_BRK means the latches are closed and a break/abort transition arrived while they were already closed. The transitions are:
- T_CAPTURE (ST_OPEN to ST_HELD): an enabled change occurs. This wins over a reset-status command in the same cycle.
- T_BRK_LATE (ST_HELD to ST_HELD_BRK): a break/abort transition occurs with no reset-status command.
- T_RELEASE (ST_HELD to ST_OPEN): reset-status with no break transition.
- T_RECAPTURE (ST_HELD_BRK or ST_HELD to ST_HELD): reset-status while a break transition is waiting or occurring. The live values are captured again and the interrupt stays pending, so no break edge is lost.

The underrun/end-of-message bit is stored inside the unit. It is set by a CRC-load pulse or by the send-abort command, held at 1 in asynchronous mode, and cleared by its own reset command. Only its set edge counts as a change. CTS and DCD come from outside the chip and pass through a synchroniser first.

The status port is read through an active-low strobe. While the strobe is low the readout holds the value captured when it fell. While the strobe is high the readout follows the status word with a lag of one cycle.

Top module: `ext_stat_latch`

## Requirements
- R1: After reset, with all sources at 0, `stat_o` is 0, `pend_o` is 0 and `irq_o` is 0. All enables are 0 after reset.
- R2: The status bit layout is: bit0 break/abort, bit1 underrun/EOM, bit2 CTS, bit3 DCD, bit4 sync/hunt, bit5 zero count. A source whose enable bit is 0 shows its live value in `stat_o` and never sets `pend_o`.
- R3: The enable write port sets enables from `en_wdata_i[5:0]`, in the bit layout of R2, and the master enable from `en_wdata_i[6]`. A change of an enabled source while nothing is pending sets `pend_o`. All enabled bits then hold the values captured in that cycle.
- R4: While pending, changes of sources other than break/abort leave `stat_o` and `pend_o` unchanged. Command code 1 (reset status) clears `pend_o` and returns every bit to its live value.
- R5: A break/abort transition while pending is never lost. The next reset-status command captures the live values again and keeps `pend_o` at 1. A second reset-status command releases the latches.
- R6: Command code 3 (send abort), or a one-cycle `crc_load_i` pulse, sets the underrun/EOM bit, and that set edge raises `pend_o`. Command code 2 clears the bit without raising `pend_o`. Code 0 is no command.
- R7: While `async_mode_i` is 1, the underrun/EOM bit stays 1, even when command code 2 is given.
- R8: `irq_o` is 1 exactly when the master enable is 1 and `pend_o` is 1.
- R9: While `rd_n_i` is low, `stat_o` keeps the value it had when the strobe fell. After the strobe rises, `stat_o` updates.
- R10: CTS and DCD pass through SYNC_STAGES flops. With the default value of 2, a change applied just after a rising edge sets `pend_o` after the third following rising edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| brk_abt_i | input | 1 | Break/abort status from the receiver |
| cts_i | input | 1 | Raw CTS pin (asynchronous) |
| dcd_i | input | 1 | Raw DCD pin (asynchronous) |
| sync_hunt_i | input | 1 | Sync/hunt status |
| zero_cnt_i | input | 1 | Zero-count status from the baud counter |
| async_mode_i | input | 1 | 1 when the channel runs in asynchronous mode |
| crc_load_i | input | 1 | Pulse when the CRC enters the transmit shift register |
| cmd_i | input | 2 | Command: 0 none, 1 reset status, 2 reset underrun, 3 send abort |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 7 | [5:0] per-source enables, [6] master enable |
| rd_n_i | input | 1 | Active-low status read strobe |
| stat_o | output | 6 | Status readout |
| pend_o | output | 1 | Interrupt pending flag |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the unit with the default SYNC_STAGES of 2. This fixes the CTS/DCD latency at three rising edges, so the bench can check the exact edge at which the pending flag rises, one cycle too early and one cycle on time. With the default setting, the bench also walks the state machine through every named transition: a late break edge held across reset-status, and the reset-status that follows. It drives the underrun bit from each of its set and clear causes, including asynchronous mode overriding the clear.

// File: rtl/ext_stat_pkg.sv
package ext_stat_pkg;
    localparam int NSRC     = 6;
    localparam int IDX_BRK  = 0;
    localparam int IDX_TXU  = 1;
    localparam int IDX_CTS  = 2;
    localparam int IDX_DCD  = 3;
    localparam int IDX_SYNC = 4;
    localparam int IDX_ZC   = 5;
    localparam int ENW      = NSRC + 1;

    typedef enum logic [1:0] {
        ST_OPEN     = 2'd0,
        ST_HELD     = 2'd1,
        ST_HELD_BRK = 2'd2
    } latch_st_e;

    typedef enum logic [1:0] {
        CMD_NONE       = 2'd0,
        CMD_RST_STAT   = 2'd1,
        CMD_RST_TXU    = 2'd2,
        CMD_SEND_ABORT = 2'd3
    } cmd_e;
endpackage

// File: rtl/ext_stat_sync.sv
module ext_stat_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < STAGES; j++) stg[j] <= '0;
        end else begin
            stg[0] <= d_i;
            for (int j = 1; j < STAGES; j++) stg[j] <= stg[j-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/ext_stat_txu.sv
module ext_stat_txu
    import ext_stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       async_mode_i,
    input  logic       crc_load_i,
    input  logic [1:0] cmd_i,
    output logic       txu_o
);
    logic set_req;
    logic clr_req;

    assign set_req = async_mode_i || crc_load_i || (cmd_i == CMD_SEND_ABORT);
    assign clr_req = (cmd_i == CMD_RST_TXU);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       txu_o <= 1'b0;
        else if (set_req) txu_o <= 1'b1;
        else if (clr_req) txu_o <= 1'b0;
    end
endmodule

// File: rtl/ext_stat_edge.sv
module ext_stat_edge
    import ext_stat_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] cur_i,
    input  logic [NSRC-1:0] en_i,
    output logic            evt_any_o,
    output logic            brk_evt_o
);
    logic [NSRC-1:0] prev_q;
    logic            armed_q;
    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            prev_q  <= cur_i;
            armed_q <= 1'b1;
        end
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_rule
        if (i == IDX_TXU) begin : g_rise_only
            assign raw[i] = cur_i[i] & ~prev_q[i];
        end else begin : g_both
            assign raw[i] = cur_i[i] ^ prev_q[i];
        end
    end

    assign evt       = raw & en_i & {NSRC{armed_q}};
    assign evt_any_o = |evt;
    assign brk_evt_o = evt[IDX_BRK];
endmodule

// File: rtl/ext_stat_fsm.sv
module ext_stat_fsm
    import ext_stat_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] cur_i,
    input  logic [NSRC-1:0] en_i,
    input  logic            evt_any_i,
    input  logic            brk_evt_i,
    input  logic            rst_cmd_i,
    output logic [NSRC-1:0] view_o,
    output logic            pend_o
);
    latch_st_e       state_q;
    latch_st_e       state_d;
    logic [NSRC-1:0] snap_q;
    logic            capture;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN: begin
                if (evt_any_i) state_d = ST_HELD;
            end
            ST_HELD: begin
                if (rst_cmd_i)      state_d = brk_evt_i ? ST_HELD : ST_OPEN;
                else if (brk_evt_i) state_d = ST_HELD_BRK;
            end
            ST_HELD_BRK: begin
                if (rst_cmd_i) state_d = ST_HELD;
            end
            default: state_d = ST_OPEN;
        endcase
    end

    assign capture = (state_q == ST_OPEN) || (rst_cmd_i && state_d == ST_HELD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       snap_q <= '0;
        else if (capture) snap_q <= cur_i;
    end

    always_comb begin
        pend_o = (state_q != ST_OPEN);
        for (int i = 0; i < NSRC; i++) begin
            view_o[i] = (pend_o && en_i[i]) ? snap_q[i] : cur_i[i];
        end
    end
endmodule

// File: rtl/ext_stat_latch.sv
module ext_stat_latch
    import ext_stat_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            brk_abt_i,
    input  logic            cts_i,
    input  logic            dcd_i,
    input  logic            sync_hunt_i,
    input  logic            zero_cnt_i,
    input  logic            async_mode_i,
    input  logic            crc_load_i,
    input  logic [1:0]      cmd_i,
    input  logic            en_we_i,
    input  logic [ENW-1:0]  en_wdata_i,
    input  logic            rd_n_i,
    output logic [NSRC-1:0] stat_o,
    output logic            pend_o,
    output logic            irq_o
);
    logic [NSRC-1:0] en_mask;
    logic            master_q;
    logic [1:0]      pins_sync;
    logic            txu_bit;
    logic [NSRC-1:0] cur;
    logic [NSRC-1:0] view;
    logic            evt_any;
    logic            brk_evt;
    logic [NSRC-1:0] rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_mask  <= '0;
            master_q <= 1'b0;
        end else if (en_we_i) begin
            en_mask  <= en_wdata_i[NSRC-1:0];
            master_q <= en_wdata_i[NSRC];
        end
    end

    ext_stat_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({dcd_i, cts_i}),
        .q_o   (pins_sync)
    );

    ext_stat_txu u_txu (
        .clk          (clk),
        .rst_n        (rst_n),
        .async_mode_i (async_mode_i),
        .crc_load_i   (crc_load_i),
        .cmd_i        (cmd_i),
        .txu_o        (txu_bit)
    );

    always_comb begin
        cur           = '0;
        cur[IDX_BRK]  = brk_abt_i;
        cur[IDX_TXU]  = txu_bit;
        cur[IDX_CTS]  = pins_sync[0];
        cur[IDX_DCD]  = pins_sync[1];
        cur[IDX_SYNC] = sync_hunt_i;
        cur[IDX_ZC]   = zero_cnt_i;
    end

    ext_stat_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur_i     (cur),
        .en_i      (en_mask),
        .evt_any_o (evt_any),
        .brk_evt_o (brk_evt)
    );

    ext_stat_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur_i     (cur),
        .en_i      (en_mask),
        .evt_any_i (evt_any),
        .brk_evt_i (brk_evt),
        .rst_cmd_i (cmd_i == CMD_RST_STAT),
        .view_o    (view),
        .pend_o    (pend_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rd_q <= '0;
        else if (rd_n_i) rd_q <= view;
    end

    assign stat_o = rd_q;
    assign irq_o  = master_q & pend_o;
endmodule

module ext_stat_chk
    import ext_stat_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      cmd_i,
    input logic            rd_n_i,
    input logic            async_mode_i,
    input logic [NSRC-1:0] stat_o,
    input logic            pend_o,
    input logic            irq_o,
    input logic            evt_any,
    input logic            brk_evt,
    input logic            txu_bit,
    input logic [NSRC-1:0] view,
    input logic [NSRC-1:0] en_mask
);
    a_r3_event_pends: assert property (@(posedge clk) disable iff (!rst_n)
        $past(evt_any && !pend_o) |-> pend_o);

    a_r4_held_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && $past(pend_o) && ($past(cmd_i) != CMD_RST_STAT) && $stable(en_mask))
        |-> $stable(view & en_mask));

    a_r5_brk_not_lost: assert property (@(posedge clk) disable iff (!rst_n)
        $past(brk_evt && (cmd_i == CMD_RST_STAT)) |-> pend_o);

    a_r7_async_txu_set: assert property (@(posedge clk) disable iff (!rst_n)
        $past(async_mode_i) |-> txu_bit);

    a_r8_irq_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> pend_o);

    a_r9_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_n_i) |-> $stable(stat_o));
endmodule

bind ext_stat_latch ext_stat_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_i        (cmd_i),
    .rd_n_i       (rd_n_i),
    .async_mode_i (async_mode_i),
    .stat_o       (stat_o),
    .pend_o       (pend_o),
    .irq_o        (irq_o),
    .evt_any      (evt_any),
    .brk_evt      (brk_evt),
    .txu_bit      (txu_bit),
    .view         (view),
    .en_mask      (en_mask)
);

// File: tb/ext_stat_latch_tb.sv
module ext_stat_latch_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       brk_abt_i = 0, cts_i = 0, dcd_i = 0, sync_hunt_i = 0, zero_cnt_i = 0;
    logic       async_mode_i = 0, crc_load_i = 0;
    logic [1:0] cmd_i = 2'd0;
    logic       en_we_i = 0;
    logic [6:0] en_wdata_i = '0;
    logic       rd_n_i = 1'b1;
    logic [5:0] stat_o;
    logic       pend_o, irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        string      tag;
        logic [5:0] stat;
        logic       pend;
        logic       irq;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_stat_latch u_dut (
        .clk(clk), .rst_n(rst_n), .brk_abt_i(brk_abt_i), .cts_i(cts_i), .dcd_i(dcd_i),
        .sync_hunt_i(sync_hunt_i), .zero_cnt_i(zero_cnt_i), .async_mode_i(async_mode_i),
        .crc_load_i(crc_load_i), .cmd_i(cmd_i), .en_we_i(en_we_i), .en_wdata_i(en_wdata_i),
        .rd_n_i(rd_n_i), .stat_o(stat_o), .pend_o(pend_o), .irq_o(irq_o)
    );

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_out(string tag, logic [5:0] s, logic p, logic i);
        exp_t e;
        e.tag = tag; e.stat = s; e.pend = p; e.irq = i;
        sb.push_back(e);
    endtask

    task automatic issue(logic [1:0] c);
        cmd_i = c;
        tick(1);
        cmd_i = 2'd0;
        tick(3);
    endtask

    task automatic write_en(logic [6:0] v);
        en_we_i = 1'b1; en_wdata_i = v;
        tick(1);
        en_we_i = 1'b0;
        tick(1);
    endtask

    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (stat_o !== e.stat || pend_o !== e.pend || irq_o !== e.irq) begin
                fails++;
                $display("FAIL %s: stat=%h pend=%b irq=%b expected stat=%h pend=%b irq=%b",
                         e.tag, stat_o, pend_o, irq_o, e.stat, e.pend, e.irq);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        expect_out("R1 reset state", 6'h00, 0, 0);

        // R2: disabled source is live, no pending
        zero_cnt_i = 1; tick(3);
        expect_out("R2 live disabled zc", 6'h20, 0, 0);
        zero_cnt_i = 0; tick(3);
        expect_out("R2 live disabled zc back", 6'h00, 0, 0);

        // R3 / R4: capture on DCD, freeze while held
        write_en(7'h7F);
        dcd_i = 1; tick(5);
        expect_out("R3 dcd capture", 6'h08, 1, 1);
        dcd_i = 0; tick(5);
        expect_out("R4 dcd frozen", 6'h08, 1, 1);
        sync_hunt_i = 1; tick(3);
        expect_out("R4 sync ignored while held", 6'h08, 1, 1);
        issue(2'd1);
        expect_out("R4 reset status reopens", 6'h10, 0, 0);
        sync_hunt_i = 0; tick(3);
        expect_out("R3 sync fall captured", 6'h00, 1, 1);
        issue(2'd1);
        expect_out("R4 released", 6'h00, 0, 0);

        // R8: master gating
        write_en(7'h3F);
        zero_cnt_i = 1; tick(3);
        expect_out("R8 master off no irq", 6'h20, 1, 0);
        write_en(7'h7F);
        expect_out("R8 master on irq", 6'h20, 1, 1);
        zero_cnt_i = 0; tick(3);
        expect_out("R4 zc frozen", 6'h20, 1, 1);
        issue(2'd1);
        expect_out("R4 released zc", 6'h00, 0, 0);

        // R5: break while held
        dcd_i = 1; tick(5);
        expect_out("R5 dcd held", 6'h08, 1, 1);
        brk_abt_i = 1; tick(3);
        expect_out("R5 brk masked while held", 6'h08, 1, 1);
        issue(2'd1);
        expect_out("R5 recapture keeps pending", 6'h09, 1, 1);
        issue(2'd1);
        expect_out("R5 second reset releases", 6'h09, 0, 0);
        brk_abt_i = 0; tick(3);
        expect_out("R5 brk fall captured", 6'h08, 1, 1);
        issue(2'd1);
        dcd_i = 0; tick(5);
        expect_out("R3 dcd fall captured", 6'h00, 1, 1);
        issue(2'd1);
        expect_out("R4 clean", 6'h00, 0, 0);

        // R6: underrun set/clear
        crc_load_i = 1; tick(1); crc_load_i = 0; tick(3);
        expect_out("R6 crc load sets", 6'h02, 1, 1);
        issue(2'd1);
        expect_out("R6 released txu", 6'h02, 0, 0);
        issue(2'd2);
        expect_out("R6 clear quiet", 6'h00, 0, 0);
        issue(2'd3);
        expect_out("R6 send abort sets", 6'h02, 1, 1);
        issue(2'd1);
        issue(2'd2);
        expect_out("R6 cleared again", 6'h00, 0, 0);

        // R7: asynchronous mode
        async_mode_i = 1; tick(3);
        expect_out("R7 async sets", 6'h02, 1, 1);
        issue(2'd1);
        issue(2'd2);
        expect_out("R7 clear overridden", 6'h02, 0, 0);
        async_mode_i = 0; tick(1);
        issue(2'd2);
        expect_out("R7 clear after async", 6'h00, 0, 0);

        // R9: read strobe hold
        write_en(7'h40);
        rd_n_i = 0; tick(1);
        zero_cnt_i = 1; tick(3);
        expect_out("R9 held during read", 6'h00, 0, 0);
        rd_n_i = 1; tick(2);
        expect_out("R9 updates after read", 6'h20, 0, 0);
        zero_cnt_i = 0; tick(3);

        // R10: CTS synchroniser latency
        write_en(7'h7F);
        cts_i = 1; tick(2);
        expect_out("R10 not yet pending", 6'h00, 0, 0);
        tick(1);
        expect_out("R10 pending on third edge", 6'h04, 1, 1);
        tick(2);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule